// File: doc/BRIEF.md
# Conversion Ready and Readout Latch

This block sits between a converter core and the serial interface that a host uses to fetch results. The core reports each finished conversion with a one-cycle strobe and a raw signed word. The block clamps that word to a 16-bit two's-complement result and tags it with a wrapping conversion count. It holds the result until the host asks for it, and it signals that a result is waiting through an active-low ready line and a ready status bit.

When the interface finishes receiving a read-data command byte, it pulses a latch strobe. On that strobe the block copies the held result and its count into the transmit holding register. Nothing else changes that register, so a conversion that finishes while a transfer is running cannot corrupt the data being shifted out. A result that arrives while a read-data command byte is still being received is staged instead. The command then loads the older result, the ready line stays low, and the staged result becomes the held result.

In continuous mode, an unread result does not leave the ready line low for ever. When the core warns that the next conversion is about to finish, the line is forced high for a fixed number of system clocks. A new falling edge can then mark the next result.

Top module: `cvr_ready_latch`

## Requirements
- R1: Out of reset `rdy_n` is 1, `rdy_stat` is 0, and `tx_data` and `tx_count` are 0.
- R2: A `conv_valid` strobe with no read-data command open drives `rdy_n` to 0 and `rdy_stat` to 1 from the next cycle.
- R3: `cmd_latch` copies the held result and its count into `tx_data`/`tx_count` from the next cycle. If no newer result is staged or arriving, `rdy_n` returns to 1 and `rdy_stat` to 0 in that same cycle.
- R4: The stored result is `conv_raw` clamped to 16 bits. Raw values above 32767 give 16'h7FFF, values below -32768 give 16'h8000, and all others give their low 16 bits.
- R5: An internal 8-bit counter advances by one, modulo 256, on every `conv_valid`. Each result carries the counter value after its own increment, so the first result after reset carries 1.
- R6: A `conv_valid` in a cycle after `cmd_begin` and before or in the cycle of `cmd_latch` does not reach the transmit register on that latch. The latch loads the previous result, `rdy_n` stays 0 and `rdy_stat` stays 1, and the next latch delivers the new result.
- R7: `tx_data` and `tx_count` change only in the cycle after `cmd_latch`, whatever `conv_valid`, `conv_next` or `cmd_begin` do.
- R8: With `cont_mode` = 1 and a result pending, a `conv_next` strobe holds `rdy_n` at 1 for exactly `PULSE_W` cycles, starting in the next cycle. `rdy_stat` stays 1 throughout, and `rdy_n` then returns to 0.
- R9: A `conv_valid` or `cmd_latch` ends a forced-high interval at once. `conv_next` has no effect when `cont_mode` = 0 or when no result is pending.
- R10: If several results arrive while one command is open, only the newest is staged and later delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid | input | 1 | One-cycle strobe: a conversion finished |
| conv_raw | input | RAW_W (18) | Raw signed conversion value |
| conv_next | input | 1 | Strobe: next conversion is about to finish |
| cont_mode | input | 1 | 1 = continuous conversion mode |
| cmd_begin | input | 1 | Strobe: a read-data command byte has started |
| cmd_latch | input | 1 | Strobe: read-data command latched, load transmit register |
| rdy_n | output | 1 | Active-low data-ready line |
| rdy_stat | output | 1 | Ready status bit, 1 while a result is unread |
| tx_data | output | DATA_W (16) | Transmit holding register, result |
| tx_count | output | CNT_W (8) | Transmit holding register, conversion count |

## Verification
The hardest case to reach from the ports is a result that lands inside the window of a read-data command byte: after `cmd_begin`, and possibly in the very cycle of `cmd_latch`. A second result can follow it before the latch, or a forced-high pulse can be running at the same moment. Directed sequences open a command, inject one or several results, then latch twice to show the old value, then the new one. A long random phase opens and latches commands and fires result and early-warning strobes at random. A cycle-level model in the bench follows every output through each of these overlaps.

// File: rtl/cvr_pkg.sv
package cvr_pkg;

  // Source chosen for the held result on a given cycle
  typedef enum logic [1:0] {
    HOLD_KEEP   = 2'd0,
    HOLD_DIRECT = 2'd1,
    HOLD_STAGED = 2'd2
  } hold_src_e;

  // Down-counter step that stops at zero
  function automatic logic [15:0] tick_down(input logic [15:0] v);
    return (v == 16'd0) ? 16'd0 : v - 16'd1;
  endfunction

endpackage

// File: rtl/cvr_clamp.sv
module cvr_clamp #(
  parameter int RAW_W  = 18,
  parameter int DATA_W = 16
) (
  input  logic [RAW_W-1:0]  raw,
  output logic [DATA_W-1:0] word
);

  localparam int EXTRA = RAW_W - DATA_W;

  generate
    if (EXTRA <= 0) begin : g_pass
      assign word = DATA_W'(raw);
    end else begin : g_clamp
      // Top EXTRA+1 bits must all equal the sign for the value to fit
      function automatic logic [DATA_W-1:0] clamp_word(input logic [RAW_W-1:0] r);
        logic [EXTRA:0] head;
        head = r[RAW_W-1:DATA_W-1];
        if ((head == '0) || (head == '1))
          return r[DATA_W-1:0];
        else if (r[RAW_W-1])
          return {1'b1, {(DATA_W-1){1'b0}}};
        else
          return {1'b0, {(DATA_W-1){1'b1}}};
      endfunction
      assign word = clamp_word(raw);
    end
  endgenerate

endmodule

// File: rtl/cvr_hold.sv
module cvr_hold
  import cvr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_word,
  input  logic              cmd_begin,
  input  logic              cmd_latch,
  output logic              pending,
  output logic              staged,
  output logic              cmd_open,
  output logic [DATA_W-1:0] tx_data,
  output logic [CNT_W-1:0]  tx_count
);

  localparam int ENT_W = DATA_W + CNT_W;

  logic [CNT_W-1:0] cnt_q;
  logic [ENT_W-1:0] held_q, stage_q, tx_q;
  logic             pend_q, stv_q, open_q;
  logic [ENT_W-1:0] new_ent;
  hold_src_e        hold_src;

  assign new_ent = {res_word, cnt_q + CNT_W'(1)};

  always_comb begin
    hold_src = HOLD_KEEP;
    if (cmd_latch) begin
      if (res_valid)  hold_src = HOLD_DIRECT;
      else if (stv_q) hold_src = HOLD_STAGED;
    end else if (!open_q && res_valid) begin
      hold_src = HOLD_DIRECT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      held_q  <= '0;
      stage_q <= '0;
      tx_q    <= '0;
      pend_q  <= 1'b0;
      stv_q   <= 1'b0;
      open_q  <= 1'b0;
    end else begin
      if (res_valid) cnt_q <= cnt_q + CNT_W'(1);
      case (hold_src)
        HOLD_DIRECT: held_q <= new_ent;
        HOLD_STAGED: held_q <= stage_q;
        default:     held_q <= held_q;
      endcase
      if (cmd_latch) begin
        tx_q   <= held_q;
        pend_q <= (hold_src != HOLD_KEEP);
        stv_q  <= 1'b0;
        open_q <= 1'b0;
      end else begin
        if (open_q && res_valid) begin
          stage_q <= new_ent;
          stv_q   <= 1'b1;
        end
        if (hold_src == HOLD_DIRECT) pend_q <= 1'b1;
        if (cmd_begin) open_q <= 1'b1;
      end
    end
  end

  assign pending  = pend_q;
  assign staged   = stv_q;
  assign cmd_open = open_q;
  assign tx_data  = tx_q[ENT_W-1:CNT_W];
  assign tx_count = tx_q[CNT_W-1:0];

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R6
  stage_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && res_valid && !cmd_latch) |=> stv_q);

  // R6
  stage_keep_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_latch && stv_q) |=> pend_q);

endmodule

// File: rtl/cvr_pulse.sv
module cvr_pulse
  import cvr_pkg::*;
#(
  parameter int PULSE_W = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clear,
  output logic active
);

  localparam int PW_W = $clog2(PULSE_W + 1);

  logic [PW_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     left_q <= '0;
    else if (clear) left_q <= '0;
    else if (start) left_q <= PW_W'(PULSE_W);
    else            left_q <= PW_W'(tick_down(16'(left_q)));
  end

  assign active = (left_q != '0);

  // R8
  pulse_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start && !clear) |=> left_q == $past(left_q) - PW_W'(1));

  // R9
  pulse_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !active);

endmodule

// File: rtl/cvr_ready_latch.sv
module cvr_ready_latch #(
  parameter int RAW_W   = 18,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 8,
  parameter int PULSE_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_valid,
  input  logic [RAW_W-1:0]  conv_raw,
  input  logic              conv_next,
  input  logic              cont_mode,
  input  logic              cmd_begin,
  input  logic              cmd_latch,
  output logic              rdy_n,
  output logic              rdy_stat,
  output logic [DATA_W-1:0] tx_data,
  output logic [CNT_W-1:0]  tx_count
);

  logic [DATA_W-1:0] res_word;
  logic              pending, staged, cmd_open;
  logic              pulse_start, pulse_clear, pulse_on;

  cvr_clamp #(.RAW_W(RAW_W), .DATA_W(DATA_W)) clamp_i (
    .raw  (conv_raw),
    .word (res_word)
  );

  cvr_hold #(.DATA_W(DATA_W), .CNT_W(CNT_W)) hold_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (conv_valid),
    .res_word  (res_word),
    .cmd_begin (cmd_begin),
    .cmd_latch (cmd_latch),
    .pending   (pending),
    .staged    (staged),
    .cmd_open  (cmd_open),
    .tx_data   (tx_data),
    .tx_count  (tx_count)
  );

  assign pulse_clear = conv_valid | cmd_latch;
  assign pulse_start = cont_mode & conv_next & pending;

  cvr_pulse #(.PULSE_W(PULSE_W)) pulse_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (pulse_start),
    .clear  (pulse_clear),
    .active (pulse_on)
  );

  assign rdy_n    = ~pending | pulse_on;
  assign rdy_stat = pending;

  // R2
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && !cmd_open && !cmd_latch) |=> (!rdy_n && rdy_stat));

  // R3
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_latch && !staged && !conv_valid) |=> (rdy_n && !rdy_stat));

  // R7
  tx_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_latch |=> ($stable(tx_data) && $stable(tx_count)));

  // R4
  clamp_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid |-> (res_word[DATA_W-1] == conv_raw[RAW_W-1]));

  // R9
  next_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_next && !cont_mode && !pulse_on && !conv_valid && !cmd_latch) |=> !pulse_on);

endmodule

// File: tb/cvr_ready_latch_tb.sv
module cvr_ready_latch_tb_top;

  localparam int RAW_W   = 18;
  localparam int PULSE_W = 40;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              conv_valid = 1'b0;
  logic [RAW_W-1:0]  conv_raw = '0;
  logic              conv_next = 1'b0;
  logic              cont_mode = 1'b0;
  logic              cmd_begin = 1'b0;
  logic              cmd_latch = 1'b0;
  logic              rdy_n, rdy_stat;
  logic [15:0]       tx_data;
  logic [7:0]        tx_count;

  int checks = 0;
  int errors = 0;

  // expected state
  logic [7:0]  m_cnt = 0;
  logic [23:0] m_held = 0, m_stage = 0, m_tx = 0;
  logic        m_pend = 0, m_stv = 0, m_open = 0;
  int          m_left = 0;

  always #10 clk = ~clk;

  cvr_ready_latch #(.RAW_W(RAW_W), .PULSE_W(PULSE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_raw(conv_raw),
    .conv_next(conv_next), .cont_mode(cont_mode), .cmd_begin(cmd_begin),
    .cmd_latch(cmd_latch), .rdy_n(rdy_n), .rdy_stat(rdy_stat),
    .tx_data(tx_data), .tx_count(tx_count)
  );

  function automatic logic [15:0] exp_clamp(input int v);
    if (v > 32767)  return 16'h7FFF;
    if (v < -32768) return 16'h8000;
    return v[15:0];
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(tag, "rdy_n", int'(rdy_n), int'(!m_pend || m_left > 0));
    check(tag, "rdy_stat", int'(rdy_stat), int'(m_pend));
    check(tag, "tx_data", int'(tx_data), int'(m_tx[23:8]));
    check(tag, "tx_count", int'(tx_count), int'(m_tx[7:0]));
  endtask

  // one clock with the given inputs, model update, compare at negedge
  task automatic step(input string tag, input bit v, input int raw, input bit nx,
                      input bit cm, input bit bg, input bit lt);
    logic [23:0] ent;
    logic [RAW_W-1:0] rv;
    rv = raw[RAW_W-1:0];
    conv_valid = v; conv_raw = rv; conv_next = nx; cont_mode = cm;
    cmd_begin = bg; cmd_latch = lt;
    @(posedge clk);
    ent = {exp_clamp(raw), m_cnt + 8'd1};
    if (v || lt) m_left = 0;
    else if (cm && nx && m_pend) m_left = PULSE_W;
    else if (m_left > 0) m_left--;
    if (lt) begin
      m_tx = m_held;
      if (v) begin m_held = ent; m_pend = 1; end
      else if (m_stv) begin m_held = m_stage; m_pend = 1; end
      else m_pend = 0;
      m_stv = 0; m_open = 0;
    end else if (m_open) begin
      if (v) begin m_stage = ent; m_stv = 1; end
      if (bg) m_open = 1;
    end else begin
      if (v) begin m_held = ent; m_pend = 1; end
      if (bg) m_open = 1;
    end
    if (v) m_cnt = m_cnt + 8'd1;
    @(negedge clk);
    conv_valid = 0; conv_next = 0; cmd_begin = 0; cmd_latch = 0;
    compare_all(tag);
  endtask

  task automatic idle(input string tag, input int n, input bit cm);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, cm, 0, 0);
  endtask

  task automatic read_out(input string tag);
    step(tag, 0, 0, 0, cont_mode, 1, 0);
    step(tag, 0, 0, 0, cont_mode, 0, 1);
  endtask

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1", "rdy_n", int'(rdy_n), 1);
    check("R1", "rdy_stat", int'(rdy_stat), 0);
    check("R1", "tx_data", int'(tx_data), 0);
    check("R1", "tx_count", int'(tx_count), 0);
    rst_n = 1'b1;
    idle("R1", 2, 0);

    // R2: result arrives, ready falls
    step("R2", 1, 100, 0, 0, 0, 0);
    check("R2", "rdy_n low", int'(rdy_n), 0);
    // R3: read it out, ready rises, tx loaded with count 1 (R5)
    read_out("R3");
    check("R3", "tx_data", int'(tx_data), 100);
    check("R5", "first count", int'(tx_count), 1);
    check("R3", "rdy_n high", int'(rdy_n), 1);

    // R4: clamp corners
    step("R4", 1, 40000, 0, 0, 0, 0);  read_out("R4");
    check("R4", "pos clamp", int'(tx_data), 16'h7FFF);
    step("R4", 1, -40000, 0, 0, 0, 0); read_out("R4");
    check("R4", "neg clamp", int'(tx_data), 16'h8000);
    step("R4", 1, -5, 0, 0, 0, 0);     read_out("R4");
    check("R4", "small neg", int'(tx_data), 16'hFFFB);
    step("R4", 1, 32767, 0, 0, 0, 0);  read_out("R4");
    step("R4", 1, -32768, 0, 0, 0, 0); read_out("R4");
    step("R4", 1, 32768, 0, 0, 0, 0);  read_out("R4");

    // R5: wrap of the counter
    for (int i = 0; i < 260; i++) step("R5", 1, i, 0, 0, 0, 0);
    read_out("R5");

    // R6: result inside the command window
    step("R6", 1, 1111, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 1, 0);
    step("R6", 1, 2222, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 1);
    check("R6", "old value", int'(tx_data), 1111);
    check("R6", "rdy_n stays low", int'(rdy_n), 0);
    read_out("R6");
    check("R6", "new value", int'(tx_data), 2222);
    // R6: result in the latch cycle itself
    step("R6", 1, 3333, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 1, 0);
    step("R6", 1, 4444, 0, 0, 0, 1);
    check("R6", "latch-cycle old", int'(tx_data), 3333);
    read_out("R6");

    // R10: several results while open
    step("R10", 0, 0, 0, 0, 1, 0);
    step("R10", 1, 10, 0, 0, 0, 0);
    step("R10", 1, 20, 0, 0, 0, 0);
    step("R10", 1, 30, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 1);
    read_out("R10");
    check("R10", "newest", int'(tx_data), 30);

    // R8: forced-high interval
    step("R8", 1, 55, 0, 1, 0, 0);
    step("R8", 0, 0, 1, 1, 0, 0);
    check("R8", "rdy_n forced", int'(rdy_n), 1);
    check("R8", "stat held", int'(rdy_stat), 1);
    idle("R8", PULSE_W + 3, 1);
    check("R8", "rdy_n back low", int'(rdy_n), 0);

    // R9: cancel by new result, then ignored cases
    step("R9", 0, 0, 1, 1, 0, 0);
    idle("R9", 5, 1);
    step("R9", 1, 66, 0, 1, 0, 0);
    check("R9", "cancelled", int'(rdy_n), 0);
    step("R9", 0, 0, 1, 0, 0, 0);
    check("R9", "single mode ignores", int'(rdy_n), 0);
    read_out("R9");
    step("R9", 0, 0, 1, 1, 0, 0);
    check("R9", "no pending ignores", int'(rdy_n), 1);
    idle("R9", 3, 1);

    // R7: random mix
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4000; i++) begin
      bit v, nx, cm, bg, lt;
      int raw;
      v  = ($urandom % 8) == 0;
      nx = ($urandom % 10) == 0;
      cm = ($urandom % 4) != 0;
      bg = !m_open && (($urandom % 10) == 0);
      lt = m_open && (($urandom % 6) == 0);
      raw = int'($urandom % 200000) - 100000;
      step("R7", v, raw, nx, cm, bg, lt);
    end
    finish_up();
  end

endmodule